// File: doc/BRIEF.md
# Glitch-Free Master Clock Source Selector

This block chooses the master clock for two groups of audio clocks. The receive group later feeds master, bit and word clock dividers; the transmit group feeds bit and word clock dividers. Three candidate clocks are offered: a clock recovered by a PLL, a free-running crystal clock, and an external master clock input. The choice follows the PLL lock status, or the sync status of the external clock, together with a few static control bits. Any change of source passes through a per-source enable handshake, so the output never shows a shortened high or low phase.

A mode bit either ties the two groups to one policy or splits them. In split mode only the receive group follows lock status, and the transmit group stays on the crystal. Force bits pin a group to the crystal whatever the lock state is. When lock is lost, a 2-bit setting delays the move to the crystal. When lock returns, the move back is not delayed. A lock status output always shows the synchronized PLL lock, whichever source is in use.

Top module: `clk_src_sel`

## Requirements
- R1: While reset is low and after it is released with lock inputs low, `rx_src` and `tx_src` read 00 (crystal) and `lock_stat` reads 0.
- R2: Source codes are 00 for crystal, 01 for PLL and 10 for external clock. Code 11 never appears on `rx_src` or `tx_src`.
- R3: With `cfg_split`=0 and `cfg_force_all`=0, both groups report 01 while the PLL is locked and 00 while it is unlocked. In this mode the two groups always report the same code.
- R4: With `cfg_split`=0 and `cfg_force_all`=1, both groups report 00 whatever the lock state.
- R5: With `cfg_split`=1, `tx_src` is always 00. `rx_src` is 00 when `cfg_force_rx`=1. Otherwise it is 01 when locked and 00 when unlocked.
- R6: With `cfg_use_ext`=1, the external clock replaces the PLL as the locked-state source and is selected while `ext_sync` is high. When `ext_sync` is low, the selection falls back to 00 and `pll_lock` has no effect on it. With `cfg_use_ext`=0, code 10 never appears.
- R7: `lock_stat` equals the synchronized `pll_lock` within four crystal cycles, in every mode and with any force bit set.
- R8: After the locked-state status falls, the move to crystal waits 0, 256, 1024 or 4096 crystal cycles for `cfg_unlock_dly` = 0, 1, 2 or 3.
- R9: When the status rises again, the locked-state source is reported within eight crystal cycles, whatever `cfg_unlock_dly` is.
- R10: The output clocks run at the frequency of the reported source. Across switches they show no high or low phase shorter than the narrowest half period among the sources.
- R11: `cfg_force_rx` has no effect when `cfg_split`=0. `cfg_force_all` has no effect when `cfg_split`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal clock; also clocks the control and selection logic |
| clk_pll | input | 1 | Clock recovered by the PLL |
| clk_ext | input | 1 | External master clock input |
| rst_n | input | 1 | Synchronous active-low reset, sampled in every clock domain |
| pll_lock | input | 1 | PLL lock status, asynchronous |
| ext_sync | input | 1 | Incoming data synchronized to the external clock, asynchronous |
| cfg_split | input | 1 | 0: groups tied; 1: transmit group held on crystal |
| cfg_force_all | input | 1 | Forces both groups to crystal in tied mode |
| cfg_force_rx | input | 1 | Forces the receive group to crystal in split mode |
| cfg_use_ext | input | 1 | External clock takes the PLL's place as the locked-state source |
| cfg_unlock_dly | input | 2 | Delay from unlock to the move to crystal: 0/256/1024/4096 cycles |
| rx_mclk | output | 1 | Receive group master clock |
| tx_mclk | output | 1 | Transmit group master clock |
| rx_src | output | 2 | Receive group selected source code |
| tx_src | output | 2 | Transmit group selected source code |
| lock_stat | output | 1 | Synchronized PLL lock status |

## Verification
On every crystal cycle, the assertions check the legality of the source codes and the truth-table rules that depend only on the control bits: the transmit group is held in split mode, each force bit pins its group, the tied groups agree, and no external code appears unless the external source is enabled. The unlock delay windows, the immediate return on relock, the fallback when the external clock loses sync, and the lock flag seen through forced modes depend on timed stimulus, so only the bench scenarios show them. The same holds for the clock-level behaviour: the frequency measured on each output and the absence of runt pulses across switches.

// File: rtl/clk_sel_pkg.sv
`timescale 1ns/1ps
// Shared source codes for the master clock selector.
// The code value equals the bit index of the source in the clock vector.
package clk_sel_pkg;
    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'b00,
        SRC_PLL  = 2'b01,
        SRC_EXT  = 2'b10
    } src_e;
endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for one asynchronous level.
// Assumes the input is held for longer than one destination clock period.
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the async level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lock_filter.sv
`timescale 1ns/1ps
// Synchronizes the lock and sync inputs into the crystal domain and
// produces a source-good flag that rises at once and falls only after
// the programmed unlock delay. Assumes clk is the always-running crystal.
module lock_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int DLY_1       = 256,
    parameter int DLY_2       = 1024,
    parameter int DLY_3       = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pll_lock_a,
    input  logic       ext_sync_a,
    input  logic       use_ext,
    input  logic [1:0] dly_sel,
    output logic       src_ok,
    output logic       lock_stat
);
    localparam int CW = $clog2(DLY_3 + 1);

    logic          pll_s, ext_s, stat;
    logic [CW-1:0] limit, cnt;
    logic          at_end;

    bit_sync #(.STAGES(SYNC_STAGES)) u_pll_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pll_lock_a), .q(pll_s));
    bit_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d_async(ext_sync_a), .q(ext_s));

    assign stat      = use_ext ? ext_s : pll_s;
    assign lock_stat = pll_s;

    // Map the 2-bit setting to a cycle count.
    always_comb begin
        case (dly_sel)
            2'd0:    limit = '0;
            2'd1:    limit = CW'(DLY_1);
            2'd2:    limit = CW'(DLY_2);
            default: limit = CW'(DLY_3);
        endcase
    end

    assign at_end = (limit == '0) || (cnt == limit - CW'(1));

    // Rise immediately on good status; fall after limit low cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ok <= 1'b0;
            cnt    <= '0;
        end else if (stat) begin
            src_ok <= 1'b1;
            cnt    <= '0;
        end else if (src_ok) begin
            if (at_end) begin
                src_ok <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/glitchless_mux.sv
`timescale 1ns/1ps
// N-input glitch-free clock multiplexer. Each source has an enable that
// is changed only on that source's falling edge, after a synchronizer in
// that domain has seen every other enable low. Assumes every source keeps
// toggling while its enable must drop.
module glitchless_mux #(
    parameter int N      = 3,
    parameter int NSYNC  = 2
) (
    input  logic [N-1:0] clks,
    input  logic         rst_n,
    input  logic [N-1:0] sel_oh,
    output logic         clk_out
);
    logic [N-1:0] en;

    for (genvar g = 0; g < N; g++) begin : g_src
        logic [NSYNC-1:0] stg;
        logic             req;

        assign req = sel_oh[g] & ~|(en & ~(N'(1) << g));

        // Synchronize the request and update the enable while clks[g] is low.
        always_ff @(negedge clks[g]) begin
            if (!rst_n) stg <= '0;
            else        stg <= {stg[NSYNC-2:0], req};
        end

        assign en[g] = stg[NSYNC-1];
    end

    assign clk_out = |(en & clks);
endmodule

// File: rtl/clk_src_sel.sv
`timescale 1ns/1ps
// Master clock source selector for a receive and a transmit clock group.
// Applies the tied/split policy with force bits and the filtered lock
// status, then drives one glitch-free multiplexer per group.
// Assumes the control bits are static between intentional changes.
module clk_src_sel
    import clk_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DLY_1       = 256,
    parameter int DLY_2       = 1024,
    parameter int DLY_3       = 4096
) (
    input  logic       clk_xtal,
    input  logic       clk_pll,
    input  logic       clk_ext,
    input  logic       rst_n,
    input  logic       pll_lock,
    input  logic       ext_sync,
    input  logic       cfg_split,
    input  logic       cfg_force_all,
    input  logic       cfg_force_rx,
    input  logic       cfg_use_ext,
    input  logic [1:0] cfg_unlock_dly,
    output logic       rx_mclk,
    output logic       tx_mclk,
    output logic [1:0] rx_src,
    output logic [1:0] tx_src,
    output logic       lock_stat
);
    logic               src_ok;
    src_e               locked_src, rx_d, tx_d, rx_q, tx_q;
    logic               rx_force;
    logic [NUM_SRC-1:0] clk_vec;

    lock_filter #(
        .SYNC_STAGES(SYNC_STAGES), .DLY_1(DLY_1), .DLY_2(DLY_2), .DLY_3(DLY_3)
    ) u_filt (
        .clk(clk_xtal), .rst_n(rst_n), .pll_lock_a(pll_lock),
        .ext_sync_a(ext_sync), .use_ext(cfg_use_ext),
        .dly_sel(cfg_unlock_dly), .src_ok(src_ok), .lock_stat(lock_stat));

    assign locked_src = cfg_use_ext ? SRC_EXT : SRC_PLL;
    assign rx_force   = cfg_split ? cfg_force_rx : cfg_force_all;

    // Selection policy for both groups.
    always_comb begin
        rx_d = (rx_force || !src_ok) ? SRC_XTAL : locked_src;
        tx_d = (cfg_split || cfg_force_all || !src_ok) ? SRC_XTAL : locked_src;
    end

    // Register the selections in the crystal domain.
    always_ff @(posedge clk_xtal) begin
        if (!rst_n) begin
            rx_q <= SRC_XTAL;
            tx_q <= SRC_XTAL;
        end else begin
            rx_q <= rx_d;
            tx_q <= tx_d;
        end
    end

    assign rx_src  = rx_q;
    assign tx_src  = tx_q;
    assign clk_vec = {clk_ext, clk_pll, clk_xtal};

    glitchless_mux #(.N(NUM_SRC), .NSYNC(SYNC_STAGES)) u_rx_mux (
        .clks(clk_vec), .rst_n(rst_n),
        .sel_oh(NUM_SRC'(1) << rx_q), .clk_out(rx_mclk));

    glitchless_mux #(.N(NUM_SRC), .NSYNC(SYNC_STAGES)) u_tx_mux (
        .clks(clk_vec), .rst_n(rst_n),
        .sel_oh(NUM_SRC'(1) << tx_q), .clk_out(tx_mclk));
endmodule

// File: rtl/clk_src_sel_chk.sv
`timescale 1ns/1ps
// Checker for the selection policy, sampled on the crystal clock.
// Bound to every instance of clk_src_sel.
module clk_src_sel_chk (
    input logic       clk_xtal,
    input logic       rst_n,
    input logic       cfg_split,
    input logic       cfg_force_all,
    input logic       cfg_force_rx,
    input logic       cfg_use_ext,
    input logic [1:0] rx_src,
    input logic [1:0] tx_src
);
    assert_code_legal_R2: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        (rx_src != 2'b11) && (tx_src != 2'b11));

    assert_tied_agree_R3: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        !cfg_split |=> rx_src == tx_src);

    assert_force_all_R4: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        (!cfg_split && cfg_force_all) |=> (rx_src == 2'b00) && (tx_src == 2'b00));

    assert_split_tx_xtal_R5: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        cfg_split |=> tx_src == 2'b00);

    assert_split_force_rx_R5: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        (cfg_split && cfg_force_rx) |=> rx_src == 2'b00);

    assert_no_ext_code_R6: assert property (@(posedge clk_xtal) disable iff (!rst_n)
        !cfg_use_ext |=> (rx_src != 2'b10) && (tx_src != 2'b10));
endmodule

bind clk_src_sel clk_src_sel_chk u_chk (
    .clk_xtal(clk_xtal), .rst_n(rst_n), .cfg_split(cfg_split),
    .cfg_force_all(cfg_force_all), .cfg_force_rx(cfg_force_rx),
    .cfg_use_ext(cfg_use_ext), .rx_src(rx_src), .tx_src(tx_src));

// File: tb/test_clk_src_sel.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected states, a monitor compares.
module test_clk_src_sel;
    logic       clk_xtal = 1'b0, clk_pll = 1'b0, clk_ext = 1'b0;
    logic       rst_n = 1'b0;
    logic       pll_lock = 1'b0, ext_sync = 1'b0;
    logic       cfg_split = 1'b0, cfg_force_all = 1'b0, cfg_force_rx = 1'b0;
    logic       cfg_use_ext = 1'b0;
    logic [1:0] cfg_unlock_dly = 2'd0;
    logic       rx_mclk, tx_mclk, lock_stat;
    logic [1:0] rx_src, tx_src;

    int n_chk = 0, n_fail = 0;
    int rx_edges = 0, tx_edges = 0, runts = 0;
    bit mon_on = 1'b0;
    realtime t_rx = 0.0, t_tx = 0.0;

    typedef struct {
        logic [1:0] rx;
        logic [1:0] tx;
        logic       lk;
        string      tag;
    } exp_t;
    exp_t q[$];
    exp_t e;

    always #2.5 clk_xtal = ~clk_xtal;
    always #3.5 clk_pll  = ~clk_pll;
    always #4.5 clk_ext  = ~clk_ext;

    clk_src_sel i_clk_src_sel (
        .clk_xtal(clk_xtal), .clk_pll(clk_pll), .clk_ext(clk_ext), .rst_n(rst_n),
        .pll_lock(pll_lock), .ext_sync(ext_sync), .cfg_split(cfg_split),
        .cfg_force_all(cfg_force_all), .cfg_force_rx(cfg_force_rx),
        .cfg_use_ext(cfg_use_ext), .cfg_unlock_dly(cfg_unlock_dly),
        .rx_mclk(rx_mclk), .tx_mclk(tx_mclk), .rx_src(rx_src), .tx_src(tx_src),
        .lock_stat(lock_stat));

    // Monitor: pop one expected item per falling crystal edge and compare.
    always @(negedge clk_xtal) begin
        if (q.size() != 0) begin
            e = q.pop_front();
            n_chk++;
            if (rx_src !== e.rx || tx_src !== e.tx || lock_stat !== e.lk) begin
                n_fail++;
                $display("FAIL %s: rx_src=%b tx_src=%b lock=%b expected rx=%b tx=%b lock=%b",
                         e.tag, rx_src, tx_src, lock_stat, e.rx, e.tx, e.lk);
            end
        end
    end

    // Edge counters and runt-pulse detection for R10.
    always @(posedge rx_mclk) rx_edges++;
    always @(posedge tx_mclk) tx_edges++;
    always @(rx_mclk) begin
        if (mon_on && ($realtime - t_rx) < 2.4) runts++;
        t_rx = $realtime;
    end
    always @(tx_mclk) begin
        if (mon_on && ($realtime - t_tx) < 2.4) runts++;
        t_tx = $realtime;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk_xtal);
        #1;
    endtask

    task automatic expect_st(input logic [1:0] rx, input logic [1:0] tx,
                             input logic lk, input string tag);
        exp_t it;
        it.rx = rx; it.tx = tx; it.lk = lk; it.tag = tag;
        q.push_back(it);
        wait_cyc(2);
    endtask

    // Count rising edges over 700 ns; the source sets the expected count.
    task automatic check_freq(input bit use_rx, input int expv, input string tag);
        int a, d;
        a = use_rx ? rx_edges : tx_edges;
        #700;
        d = (use_rx ? rx_edges : tx_edges) - a;
        n_chk++;
        if (d < expv - 2 || d > expv + 2) begin
            n_fail++;
            $display("FAIL %s: edges=%0d expected=%0d", tag, d, expv);
        end
    endtask

    initial begin
        #500us;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(10);
        expect_st(2'b00, 2'b00, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        wait_cyc(20);
        expect_st(2'b00, 2'b00, 1'b0, "R1 after reset");
        mon_on = 1'b1;
        check_freq(1'b1, 140, "R10 rx on crystal");

        // Tied mode, lock follows.
        pll_lock = 1'b1; wait_cyc(20);
        expect_st(2'b01, 2'b01, 1'b1, "R3 locked");
        check_freq(1'b1, 100, "R10 rx on PLL");
        check_freq(1'b0, 100, "R10 tx on PLL");
        pll_lock = 1'b0; wait_cyc(20);
        expect_st(2'b00, 2'b00, 1'b0, "R3 unlocked");
        check_freq(1'b0, 140, "R10 tx back to crystal");

        pll_lock = 1'b1; cfg_force_all = 1'b1; wait_cyc(20);
        expect_st(2'b00, 2'b00, 1'b1, "R4 force all, R7 lock visible");
        cfg_force_all = 1'b0; cfg_force_rx = 1'b1; wait_cyc(20);
        expect_st(2'b01, 2'b01, 1'b1, "R11 force_rx ignored when tied");

        // Split mode.
        cfg_split = 1'b1; cfg_force_rx = 1'b0; wait_cyc(20);
        expect_st(2'b01, 2'b00, 1'b1, "R5 split locked");
        check_freq(1'b0, 140, "R5 tx held on crystal");
        cfg_force_all = 1'b1; wait_cyc(20);
        expect_st(2'b01, 2'b00, 1'b1, "R11 force_all ignored when split");
        cfg_force_all = 1'b0; cfg_force_rx = 1'b1; wait_cyc(20);
        expect_st(2'b00, 2'b00, 1'b1, "R5 split force rx");
        cfg_force_rx = 1'b0; pll_lock = 1'b0; wait_cyc(20);
        expect_st(2'b00, 2'b00, 1'b0, "R5 split unlocked");

        // External source.
        cfg_split = 1'b0; cfg_use_ext = 1'b1; ext_sync = 1'b1; pll_lock = 1'b1;
        wait_cyc(20);
        expect_st(2'b10, 2'b10, 1'b1, "R6 external selected");
        check_freq(1'b1, 78, "R10 rx on external");
        pll_lock = 1'b0; wait_cyc(20);
        expect_st(2'b10, 2'b10, 1'b0, "R6 PLL unlock ignored, R7 lock low");
        ext_sync = 1'b0; pll_lock = 1'b1; wait_cyc(20);
        expect_st(2'b00, 2'b00, 1'b1, "R6 sync lost falls back");
        cfg_use_ext = 1'b0; wait_cyc(20);
        expect_st(2'b01, 2'b01, 1'b1, "R6 back to PLL");

        // Unlock delays and relock.
        cfg_unlock_dly = 2'd1; pll_lock = 1'b0; wait_cyc(100);
        expect_st(2'b01, 2'b01, 1'b0, "R8 delay 256 still PLL");
        wait_cyc(200);
        expect_st(2'b00, 2'b00, 1'b0, "R8 delay 256 expired");
        pll_lock = 1'b1; wait_cyc(6);
        expect_st(2'b01, 2'b01, 1'b1, "R9 relock fast");
        cfg_unlock_dly = 2'd2; pll_lock = 1'b0; wait_cyc(900);
        expect_st(2'b01, 2'b01, 1'b0, "R8 delay 1024 still PLL");
        wait_cyc(200);
        expect_st(2'b00, 2'b00, 1'b0, "R8 delay 1024 expired");
        pll_lock = 1'b1; wait_cyc(20);
        cfg_unlock_dly = 2'd3; pll_lock = 1'b0; wait_cyc(4000);
        expect_st(2'b01, 2'b01, 1'b0, "R8 delay 4096 still PLL");
        wait_cyc(150);
        expect_st(2'b00, 2'b00, 1'b0, "R8 delay 4096 expired");
        pll_lock = 1'b1; wait_cyc(6);
        expect_st(2'b01, 2'b01, 1'b1, "R9 relock with long delay set");
        cfg_unlock_dly = 2'd0; pll_lock = 1'b0; wait_cyc(10);
        expect_st(2'b00, 2'b00, 1'b0, "R8 zero delay");

        wait_cyc(10);
        n_chk++;
        if (runts != 0) begin
            n_fail++;
            $display("FAIL R10 runt pulses: count=%0d expected=0", runts);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule